// File: doc/BRIEF.md
# Block Transfer and Search Sequencer

This block carries out one step of the repeating, downward-counting block operations of an 8-bit processor. A single start strobe selects one of three operations. Search compares the accumulator with the byte at the memory pointer. Copy moves the byte at the source pointer to the destination pointer. Input fetches a byte from an I/O port and stores it at the memory pointer. For each step the block produces the updated pointer and counter registers, the updated flag byte, the program counter, a repeat indication and the number of T-states the step costs.

The surrounding core latches the register values on the inputs when it raises start. It then waits for the one-cycle done pulse and copies the results back. The block has one memory port with a single read and an optional single write per step, and one I/O read port. Read data on either port is expected one clock after its read strobe. When the step must run again, the returned program counter is rewound by two, so the core refetches the same instruction. The core can take interrupts between steps without the block knowing.

Top module: `blkop_seq`

## Requirements
- R1: While reset is asserted and right after it is released, done, mem_rd, mem_wr and io_rd are low, and all result outputs read zero.
- R2: Search (mode 2'b00) reads memory once at HL and writes nothing. It returns HL-1 and BC-1 and leaves DE unchanged.
- R3: Search sets the flags from the fetched byte d. Flag bit 7 (S) is A<d taken as unsigned. Bit 6 (Z) is A==d. Bit 4 (H) is A[3:0]<d[3:0]. Bit 2 (P/V) is set when the returned BC is nonzero. Bit 1 (N) is 1. Bits 5, 3 and 0 (carry) keep their input value.
- R4: Search repeats when A!=d and the returned BC is nonzero. A repeating step reports 21 T-states, rpt_o=1 and PC-2. Any other search step reports 16 T-states, rpt_o=0 and PC unchanged.
- R5: Copy (mode 2'b01) reads the byte at HL and writes it once to memory at DE. It returns HL-1, DE-1 and BC-1. It clears bit 4 and bit 1 and sets bit 2 when the returned BC is nonzero, and keeps bits 7, 6, 5, 3 and 0. It never repeats: 16 T-states, PC unchanged.
- R6: Input (mode 2'b10) reads the I/O port once at address {B,C}, where B is BC[15:8] and C is BC[7:0]. It writes the byte once to memory at HL and returns HL-1 and B-1, with C and DE unchanged. It sets bits 6 and 1 and keeps every other flag bit.
- R7: Input repeats when the returned B is nonzero, reporting 21 T-states and PC-2. Otherwise it reports 16 T-states and PC unchanged.
- R8: Every decrement wraps. HL, DE or BC of zero becomes 16'hFFFF, and B of zero becomes 8'hFF. A counter that wraps this way is nonzero, so the step repeats.
- R9: A start with mode 2'b11 is ignored: no strobe and no done follow.
- R10: Each accepted start gives exactly one done pulse, one clock wide, and at most one of mem_rd, mem_wr, io_rd and done is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches one step when the block is idle |
| mode | input | 2 | 00 search, 01 copy, 10 input, 11 ignored |
| a_in | input | 8 | Accumulator value |
| hl_in | input | 16 | Memory pointer |
| de_in | input | 16 | Destination pointer |
| bc_in | input | 16 | Counter pair (B high byte, C low byte) |
| pc_in | input | 16 | Program counter of the instruction |
| flags_in | input | 8 | Flag byte before the step |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one clock after mem_rd |
| io_addr | output | 16 | I/O port address |
| io_rd | output | 1 | I/O read strobe |
| io_rdata | input | 8 | I/O read data, one clock after io_rd |
| done | output | 1 | One-cycle pulse, results valid |
| rpt_o | output | 1 | Step must run again |
| tstates | output | 5 | T-state cost of the step |
| hl_o | output | 16 | Updated memory pointer |
| de_o | output | 16 | Updated destination pointer |
| bc_o | output | 16 | Updated counter pair |
| pc_o | output | 16 | Program counter to continue from |
| flags_o | output | 8 | Updated flag byte |

## Verification
Search is swept over all 256 accumulator values against several pointers. Each pointer yields a different fetched byte, so every pointer has exactly one match, plus values below and above the byte and values that differ only in the low nibble. This separates the sign, zero and half-borrow flags. The counter cycles through 1, 2, 0 and a large value, which separates the match stop from the count-exhausted stop and the wrapping repeat. Copy and input are swept with pointers and counters that include zero and one, and varied flag bytes show that the untouched bits survive. An unused mode code is checked for silence at the ports.

// File: rtl/blkop_pkg.sv
package blkop_pkg;

   typedef enum logic [1:0] {
      OP_SEARCH = 2'b00,
      OP_COPY   = 2'b01,
      OP_INPUT  = 2'b10,
      OP_NONE   = 2'b11
   } blk_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_CAPT,
      ST_WRITE,
      ST_DONE
   } seq_state_e;

   localparam int FL_S  = 7;
   localparam int FL_Z  = 6;
   localparam int FL_H  = 4;
   localparam int FL_PV = 2;
   localparam int FL_N  = 1;
   localparam int FL_C  = 0;

endpackage

// File: rtl/blkop_flagmix.sv
module blkop_flagmix #(
   parameter int W = 8
) (
   input  logic [W-1:0] old_f,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] val,
   output logic [W-1:0] new_f
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign new_f[i] = mask[i] ? val[i] : old_f[i];
   end

endmodule

// File: rtl/blkop_calc.sv
module blkop_calc
   import blkop_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 8,
   parameter int TSW     = 5,
   parameter int TS_END  = 16,
   parameter int TS_RPT  = 21,
   parameter int PC_STEP = 2
) (
   input  blk_op_e         op,
   input  logic [DW-1:0]   a,
   input  logic [AW-1:0]   hl,
   input  logic [AW-1:0]   de,
   input  logic [AW-1:0]   bc,
   input  logic [AW-1:0]   pc,
   input  logic [DW-1:0]   flg,
   input  logic [DW-1:0]   dat,
   output logic [AW-1:0]   hl_n,
   output logic [AW-1:0]   de_n,
   output logic [AW-1:0]   bc_n,
   output logic [AW-1:0]   pc_n,
   output logic [DW-1:0]   flg_n,
   output logic            rpt,
   output logic [TSW-1:0]  ts,
   output logic [AW-1:0]   wr_addr
);

   localparam logic [AW-1:0] ONE_W = AW'(1);
   localparam logic [DW-1:0] ONE_B = DW'(1);

   logic [AW-1:0] hl_dec, de_dec, bc_dec;
   logic [DW-1:0] b_dec;
   logic          bc_live, b_live, match;
   logic [DW-1:0] fmask, fval;

   assign hl_dec  = hl - ONE_W;
   assign de_dec  = de - ONE_W;
   assign bc_dec  = bc - ONE_W;
   assign b_dec   = bc[AW-1:DW] - ONE_B;
   assign bc_live = (bc_dec != '0);
   assign b_live  = (b_dec != '0);
   assign match   = (a == dat);

   always_comb begin
      hl_n    = hl;
      de_n    = de;
      bc_n    = bc;
      rpt     = 1'b0;
      wr_addr = hl;
      fmask   = '0;
      fval    = '0;
      unique case (op)
         OP_SEARCH: begin
            hl_n         = hl_dec;
            bc_n         = bc_dec;
            rpt          = !match && bc_live;
            fmask[FL_S]  = 1'b1;
            fmask[FL_Z]  = 1'b1;
            fmask[FL_H]  = 1'b1;
            fmask[FL_PV] = 1'b1;
            fmask[FL_N]  = 1'b1;
            fval[FL_S]   = (a < dat);
            fval[FL_Z]   = match;
            fval[FL_H]   = (a[3:0] < dat[3:0]);
            fval[FL_PV]  = bc_live;
            fval[FL_N]   = 1'b1;
         end
         OP_COPY: begin
            hl_n         = hl_dec;
            de_n         = de_dec;
            bc_n         = bc_dec;
            wr_addr      = de;
            fmask[FL_H]  = 1'b1;
            fmask[FL_N]  = 1'b1;
            fmask[FL_PV] = 1'b1;
            fval[FL_PV]  = bc_live;
         end
         OP_INPUT: begin
            hl_n         = hl_dec;
            bc_n         = {b_dec, bc[DW-1:0]};
            rpt          = b_live;
            fmask[FL_Z]  = 1'b1;
            fmask[FL_N]  = 1'b1;
            fval[FL_Z]   = 1'b1;
            fval[FL_N]   = 1'b1;
         end
         default: ;
      endcase
   end

   assign pc_n = rpt ? (pc - AW'(PC_STEP)) : pc;
   assign ts   = rpt ? TSW'(TS_RPT) : TSW'(TS_END);

   blkop_flagmix #(.W(DW)) u_mix (
      .old_f (flg),
      .mask  (fmask),
      .val   (fval),
      .new_f (flg_n)
   );

endmodule

// File: rtl/blkop_fsm.sv
module blkop_fsm
   import blkop_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  blk_op_e    op_in,
   input  blk_op_e    op_q,
   output seq_state_e state,
   output logic       accept
);

   seq_state_e nxt;

   assign accept = (state == ST_IDLE) && start && (op_in != OP_NONE);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (accept) nxt = ST_READ;
         ST_READ:  nxt = ST_CAPT;
         ST_CAPT:  nxt = (op_q == OP_SEARCH) ? ST_DONE : ST_WRITE;
         ST_WRITE: nxt = ST_DONE;
         ST_DONE:  nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

endmodule

// File: rtl/blkop_seq.sv
module blkop_seq
   import blkop_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 8,
   parameter int TSW     = 5,
   parameter int TS_END  = 16,
   parameter int TS_RPT  = 21,
   parameter int PC_STEP = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [1:0]      mode,
   input  logic [DW-1:0]   a_in,
   input  logic [AW-1:0]   hl_in,
   input  logic [AW-1:0]   de_in,
   input  logic [AW-1:0]   bc_in,
   input  logic [AW-1:0]   pc_in,
   input  logic [DW-1:0]   flags_in,
   output logic [AW-1:0]   mem_addr,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata,
   output logic [AW-1:0]   io_addr,
   output logic            io_rd,
   input  logic [DW-1:0]   io_rdata,
   output logic            done,
   output logic            rpt_o,
   output logic [TSW-1:0]  tstates,
   output logic [AW-1:0]   hl_o,
   output logic [AW-1:0]   de_o,
   output logic [AW-1:0]   bc_o,
   output logic [AW-1:0]   pc_o,
   output logic [DW-1:0]   flags_o
);

   if (AW != 2 * DW) begin : g_bad_width
      $error("register pair width must be twice the data width");
   end
   if (DW < 8) begin : g_bad_data
      $error("data width must hold the flag byte");
   end
   if ((TS_RPT >= (1 << TSW)) || (TS_END >= (1 << TSW))) begin : g_bad_ts
      $error("T-state counts do not fit the count width");
   end

   seq_state_e state;
   logic       accept;
   blk_op_e    op_q;

   logic [DW-1:0] a_q, flg_q, dat_q;
   logic [AW-1:0] hl_q, de_q, bc_q, pc_q, wr_addr_q;

   logic [DW-1:0]  dat_sel, flg_n;
   logic [AW-1:0]  hl_n, de_n, bc_n, pc_n, wr_n;
   logic           rpt_n;
   logic [TSW-1:0] ts_n;

   blkop_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .op_in  (blk_op_e'(mode)),
      .op_q   (op_q),
      .state  (state),
      .accept (accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_SEARCH;
         a_q   <= '0;
         flg_q <= '0;
         hl_q  <= '0;
         de_q  <= '0;
         bc_q  <= '0;
         pc_q  <= '0;
      end else if (accept) begin
         op_q  <= blk_op_e'(mode);
         a_q   <= a_in;
         flg_q <= flags_in;
         hl_q  <= hl_in;
         de_q  <= de_in;
         bc_q  <= bc_in;
         pc_q  <= pc_in;
      end
   end

   assign dat_sel = (op_q == OP_INPUT) ? io_rdata : mem_rdata;

   blkop_calc #(
      .AW(AW), .DW(DW), .TSW(TSW),
      .TS_END(TS_END), .TS_RPT(TS_RPT), .PC_STEP(PC_STEP)
   ) u_calc (
      .op      (op_q),
      .a       (a_q),
      .hl      (hl_q),
      .de      (de_q),
      .bc      (bc_q),
      .pc      (pc_q),
      .flg     (flg_q),
      .dat     (dat_sel),
      .hl_n    (hl_n),
      .de_n    (de_n),
      .bc_n    (bc_n),
      .pc_n    (pc_n),
      .flg_n   (flg_n),
      .rpt     (rpt_n),
      .ts      (ts_n),
      .wr_addr (wr_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hl_o      <= '0;
         de_o      <= '0;
         bc_o      <= '0;
         pc_o      <= '0;
         flags_o   <= '0;
         rpt_o     <= 1'b0;
         tstates   <= '0;
         dat_q     <= '0;
         wr_addr_q <= '0;
      end else if (state == ST_CAPT) begin
         hl_o      <= hl_n;
         de_o      <= de_n;
         bc_o      <= bc_n;
         pc_o      <= pc_n;
         flags_o   <= flg_n;
         rpt_o     <= rpt_n;
         tstates   <= ts_n;
         dat_q     <= dat_sel;
         wr_addr_q <= wr_n;
      end
   end

   assign mem_rd    = (state == ST_READ) && (op_q != OP_INPUT);
   assign io_rd     = (state == ST_READ) && (op_q == OP_INPUT);
   assign mem_wr    = (state == ST_WRITE);
   assign mem_addr  = (state == ST_WRITE) ? wr_addr_q : hl_q;
   assign mem_wdata = dat_q;
   assign io_addr   = bc_q;
   assign done      = (state == ST_DONE);

endmodule

// File: rtl/blkop_seq_chk.sv
module blkop_seq_chk
   import blkop_pkg::*;
#(
   parameter int AW     = 16,
   parameter int DW     = 8,
   parameter int TSW    = 5,
   parameter int TS_END = 16,
   parameter int TS_RPT = 21
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [1:0]     mode,
   input logic           done,
   input logic           rpt_o,
   input logic [TSW-1:0] tstates,
   input logic           mem_rd,
   input logic           mem_wr,
   input logic           io_rd,
   input logic [DW-1:0]  flags_o,
   input logic [AW-1:0]  bc_o
);

   logic    busy;
   blk_op_e op_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         op_c <= OP_SEARCH;
      end else if (done) begin
         busy <= 1'b0;
      end else if (!busy && start && (blk_op_e'(mode) != OP_NONE)) begin
         busy <= 1'b1;
         op_c <= blk_op_e'(mode);
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!done && !mem_rd && !mem_wr && !io_rd);
      end
   end

   assert_no_search_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_c == OP_SEARCH) |-> (!mem_wr && !io_rd));

   assert_pv_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_c == OP_SEARCH) |-> (flags_o[FL_PV] == (bc_o != '0)));

   assert_ts_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rpt_o) |-> (tstates == TSW'(TS_RPT)));

   assert_copy_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_c == OP_COPY) |-> (!rpt_o && !flags_o[FL_H] && !flags_o[FL_N]));

   assert_input_zn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_c == OP_INPUT) |-> (flags_o[FL_Z] && flags_o[FL_N]));

   assert_input_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_c == OP_INPUT) |-> (rpt_o == (bc_o[AW-1:DW] != '0)));

   assert_ts_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rpt_o) |-> (tstates == TSW'(TS_END)));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mem_rd || mem_wr || io_rd || done));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, io_rd, done}));

endmodule

bind blkop_seq blkop_seq_chk #(
   .AW(AW), .DW(DW), .TSW(TSW), .TS_END(TS_END), .TS_RPT(TS_RPT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .mode    (mode),
   .done    (done),
   .rpt_o   (rpt_o),
   .tstates (tstates),
   .mem_rd  (mem_rd),
   .mem_wr  (mem_wr),
   .io_rd   (io_rd),
   .flags_o (flags_o),
   .bc_o    (bc_o)
);

// File: tb/blkop_seq_bench.sv
`timescale 1ns/1ps
module blkop_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [7:0]  a_in = '0, flags_in = '0;
   logic [15:0] hl_in = '0, de_in = '0, bc_in = '0, pc_in = '0;
   logic [15:0] mem_addr, io_addr;
   logic        mem_rd, mem_wr, io_rd, done, rpt_o;
   logic [7:0]  mem_wdata, flags_o;
   logic [7:0]  mem_rdata = '0, io_rdata = '0;
   logic [4:0]  tstates;
   logic [15:0] hl_o, de_o, bc_o, pc_o;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   int rd_cnt = 0, wr_cnt = 0, io_cnt = 0;
   logic [15:0] last_wr_addr = '0, last_io_addr = '0;
   logic [7:0]  last_wr_data = '0;

   always #4 clk = ~clk;

   blkop_seq u_blkop_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .a_in(a_in), .hl_in(hl_in), .de_in(de_in), .bc_in(bc_in),
      .pc_in(pc_in), .flags_in(flags_in),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .io_addr(io_addr), .io_rd(io_rd), .io_rdata(io_rdata),
      .done(done), .rpt_o(rpt_o), .tstates(tstates),
      .hl_o(hl_o), .de_o(de_o), .bc_o(bc_o), .pc_o(pc_o), .flags_o(flags_o)
   );

   function automatic logic [7:0] memf(input logic [15:0] ad);
      logic [7:0] t;
      t = ad[7:0] * 8'd5;
      return t + ad[15:8] + 8'd3;
   endfunction

   function automatic logic [7:0] iof(input logic [15:0] ad);
      return ad[7:0] ^ ad[15:8] ^ 8'h5A;
   endfunction

   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= memf(mem_addr);
         rd_cnt    <= rd_cnt + 1;
      end
      if (io_rd) begin
         io_rdata     <= iof(io_addr);
         last_io_addr <= io_addr;
         io_cnt       <= io_cnt + 1;
      end
      if (mem_wr) begin
         last_wr_addr <= mem_addr;
         last_wr_data <= mem_wdata;
         wr_cnt       <= wr_cnt + 1;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   int rd_b, wr_b, io_b;

   task automatic run_op(input logic [1:0] m, input logic [7:0] a,
                         input logic [15:0] hl, input logic [15:0] de,
                         input logic [15:0] bc, input logic [15:0] pc,
                         input logic [7:0] fl);
      bit seen;
      @(negedge clk);
      rd_b = rd_cnt; wr_b = wr_cnt; io_b = io_cnt;
      mode = m; a_in = a; hl_in = hl; de_in = de; bc_in = bc; pc_in = pc;
      flags_in = fl; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = 0;
      for (int k = 0; k < 20; k++) begin
         if (done) begin
            seen = 1;
            break;
         end
         @(negedge clk);
      end
      chk("R10 done pulse seen", {63'd0, seen}, 64'd1);
   endtask

   task automatic check_done_drop();
      @(negedge clk);
      chk("R10 done one cycle wide", {63'd0, done}, 64'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0]  d, ef;
      logic [15:0] hl, de, bc, pc, bcn;
      logic        match, more, rep;

      repeat (3) @(negedge clk);
      chk("R1 strobes in reset", {60'd0, done, mem_rd, mem_wr, io_rd}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 strobes after reset", {60'd0, done, mem_rd, mem_wr, io_rd}, 64'd0);
      chk("R1 outputs after reset", {hl_o, bc_o, pc_o, flags_o, 2'b0, rpt_o, tstates}, 64'd0);
      chk("R1 de after reset", {48'd0, de_o}, 64'd0);

      // search sweep: R2 R3 R4
      for (int h = 0; h < 4; h++) begin
         hl = 16'h1234 + 16'(h) * 16'h0F17;
         for (int ai = 0; ai < 256; ai++) begin
            unique case (ai % 4)
               0: bc = 16'h0001;
               1: bc = 16'h0002;
               2: bc = 16'h0000;
               default: bc = 16'h8000;
            endcase
            de = 16'hA5A5 ^ 16'(ai);
            pc = 16'(ai) * 16'h0101;
            d  = memf(hl);
            bcn = bc - 16'd1;
            match = (8'(ai) == d);
            more  = (bcn != 16'd0);
            rep   = !match && more;
            ef = 8'(ai * 37 + h);
            ef[7] = (8'(ai) < d);
            ef[6] = match;
            ef[4] = (ai[3:0] < d[3:0]);
            ef[2] = more;
            ef[1] = 1'b1;
            run_op(2'b00, 8'(ai), hl, de, bc, pc, 8'(ai * 37 + h));
            chk("R2 search registers", {16'd0, hl_o, de_o, bc_o},
                {16'd0, hl - 16'd1, de, bcn});
            chk("R2 search port use", {32'(rd_cnt - rd_b), 16'(wr_cnt - wr_b), 16'(io_cnt - io_b)},
                {32'd1, 16'd0, 16'd0});
            chk("R3 search flags", {56'd0, flags_o}, {56'd0, ef});
            chk("R4 search repeat", {42'd0, rpt_o, tstates, pc_o},
                {42'd0, rep, rep ? 5'd21 : 5'd16, rep ? pc - 16'd2 : pc});
            check_done_drop();
         end
      end

      // copy sweep: R5
      for (int i = 0; i < 256; i++) begin
         hl = 16'(i) * 16'h0101;
         de = 16'(255 - i) * 16'h0100 + 16'(i);
         bc = {8'(i >> 1), 8'(i)};
         pc = 16'h4000 + 16'(i);
         bcn = bc - 16'd1;
         ef = 8'(i * 91);
         ef[4] = 1'b0;
         ef[1] = 1'b0;
         ef[2] = (bcn != 16'd0);
         run_op(2'b01, 8'(i), hl, de, bc, pc, 8'(i * 91));
         chk("R5 copy registers", {16'd0, hl_o, de_o, bc_o},
             {16'd0, hl - 16'd1, de - 16'd1, bcn});
         chk("R5 copy flags", {56'd0, flags_o}, {56'd0, ef});
         chk("R5 copy finish", {42'd0, rpt_o, tstates, pc_o}, {42'd0, 1'b0, 5'd16, pc});
         chk("R5 copy write", {8'd0, 16'(rd_cnt - rd_b), 16'(wr_cnt - wr_b), last_wr_addr, last_wr_data},
             {8'd0, 16'd1, 16'd1, de, memf(hl)});
         check_done_drop();
      end

      // input sweep: R6 R7
      for (int i = 0; i < 256; i++) begin
         hl = 16'(i) * 16'h0101 + 16'd7;
         de = 16'h3C3C + 16'(i);
         bc = {8'(i), 8'(i) ^ 8'h33};
         pc = 16'(i) * 16'h0203;
         ef = 8'(i * 53);
         ef[6] = 1'b1;
         ef[1] = 1'b1;
         rep = ((8'(i) - 8'd1) != 8'd0);
         run_op(2'b10, 8'h00, hl, de, bc, pc, 8'(i * 53));
         chk("R6 input registers", {16'd0, hl_o, de_o, bc_o},
             {16'd0, hl - 16'd1, de, 8'(i) - 8'd1, bc[7:0]});
         chk("R6 input flags", {56'd0, flags_o}, {56'd0, ef});
         chk("R6 input ports", {16'(io_cnt - io_b), 16'(wr_cnt - wr_b), last_io_addr, last_wr_addr},
             {16'd1, 16'd1, bc, hl});
         chk("R6 input data", {56'd0, last_wr_data}, {56'd0, iof(bc)});
         chk("R7 input repeat", {42'd0, rpt_o, tstates, pc_o},
             {42'd0, rep, rep ? 5'd21 : 5'd16, rep ? pc - 16'd2 : pc});
         check_done_drop();
      end

      // wrap cases: R8
      run_op(2'b00, 8'h00, 16'h0000, 16'h1111, 16'h0000, 16'h0001, 8'h00);
      chk("R8 search wrap", {15'd0, hl_o, bc_o, pc_o, rpt_o},
          {15'd0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1});
      check_done_drop();
      run_op(2'b01, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0100, 8'h00);
      chk("R8 copy wrap", {16'd0, hl_o, de_o, bc_o}, {16'd0, 16'hFFFF, 16'hFFFF, 16'hFFFF});
      chk("R8 copy wrap pv", {63'd0, flags_o[2]}, 64'd1);
      check_done_drop();
      run_op(2'b10, 8'h00, 16'h0000, 16'h2222, 16'h0055, 16'h0200, 8'h00);
      chk("R8 input wrap", {15'd0, hl_o, bc_o, pc_o, rpt_o},
          {15'd0, 16'hFFFF, 16'hFF55, 16'h01FE, 1'b1});
      check_done_drop();

      // ignored mode: R9
      @(negedge clk);
      rd_b = rd_cnt; wr_b = wr_cnt; io_b = io_cnt;
      mode = 2'b11; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      begin
         bit any_done;
         any_done = 0;
         for (int k = 0; k < 8; k++) begin
            if (done || mem_rd || mem_wr || io_rd) any_done = 1;
            @(negedge clk);
         end
         chk("R9 unused mode silent", {63'd0, any_done}, 64'd0);
         chk("R9 unused mode no access", {16'd0, 16'(rd_cnt - rd_b), 16'(wr_cnt - wr_b), 16'(io_cnt - io_b)}, 64'd0);
      end

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule